// File: doc/BRIEF.md
# Reset-Time Operating Mode Selector

This block chooses the operating mode of the device after every system reset. It also sets the hardware flash write protection that belongs to that mode. A system reset comes from any of four sources: power-on, the external reset pin, a software request or a brown-out. When the reset ends, the block watches two strap pins and a mode-select-enable pin for a fixed sampling window. It then decodes them together with a lock bit read from nonvolatile configuration. The result is a one-hot mode. The mode stays constant until the next system reset.

A test-enable pin overrides everything else. While it is high, the block reports scan test mode at once, whatever the reset or sampling state. Scan mode ends only when the pin has gone low and a full system reset has followed.

For each mode the block drives three outputs: a write-protect enable, a write-protect base address, and a gate that keeps software from setting the flash program and erase control bits. It also raises a reduced-command flag for a locked test mode. It keeps a sticky error flag for strap pins that moved during the sampling window. The sampling window `SAMPLE_CYC` must be at least 2.

Top module: `opm_mode_select`

## Requirements
- R1: While any reset source is active, and for 2 clock edges after the last one is removed, `mode_oh` is 0, `wp_en` and `ctl_wr_block` are 1, `wp_base` is 0 and `reduced_cmd` is 0. Sources: `por_n` low, `ext_rst_n` low, `brownout` high, or `sw_rst_req` high at a clock edge.
- R2: While `test_en` is high, `mode_oh` equals 5'b10000 (scan) with no clock edge needed, overriding resets and strap decode.
- R3: After `test_en` falls, scan mode is kept until a system reset occurs. The next mode is then decided by a fresh sampling window.
- R4: With mode-select-enable (`msel_en`) low during sampling, the mode is normal (`mode_oh` bit 0) for every strap value.
- R5: `mode_oh` bits are normal=0, programming=1, debug=2, test=3, scan=4, and at most one bit is set. With `msel_en` high, the strap word {`strap_hi`,`strap_lo`} selects the mode: 00 gives test, 01 gives programming (normal if `lock_bit` is 1), 10 gives debug (normal if `lock_bit` is 1), and 11 gives normal.
- R6: `reduced_cmd` is 1 exactly when the mode is test and `lock_bit` was 1 when the mode was decided.
- R7: The write-protect outputs depend on the mode:

  | Mode | `wp_en` | `wp_base` |
  |---|---|---|
  | Normal | 1 | `PROT_BASE` |
  | Debug, scan, undecided | 1 | 0 |
  | Programming, test | 0 | 0 |
- R8: `ctl_wr_block` is 1 in every mode that restricts flash writes and 0 in programming and test modes.
- R9: Pins pass through two synchronising flops. Sampling starts on the edge after the system reset ends and lasts `SAMPLE_CYC` edges. The mode appears after edge `SAMPLE_CYC`+2 counted from the removal of the reset request.
- R10: If a synchronised sample of {`msel_en`,`strap_hi`,`strap_lo`} in the window differs from the first sample, the mode is normal and `strap_err` is set. `strap_err` is cleared only by power-on reset.
- R11: Once decided, the mode and the lock value do not change on pin activity until the next system reset or a scan entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sw_rst_req | input | 1 | Software reset request, synchronous, one cycle |
| brownout | input | 1 | Brown-out event, active high, asynchronous |
| test_en | input | 1 | Scan test enable pin, asynchronous override |
| msel_en | input | 1 | Mode-select-enable pin |
| strap_hi | input | 1 | Strap bit, high position of the strap word |
| strap_lo | input | 1 | Strap bit, low position of the strap word |
| lock_bit | input | 1 | Nonvolatile lock bit |
| mode_oh | output | 5 | One-hot operating mode |
| reduced_cmd | output | 1 | Reduced test command set in force |
| wp_en | output | 1 | Flash write protection active |
| wp_base | output | ADDR_W | Lowest protected flash address |
| ctl_wr_block | output | 1 | Writes of 1 to program/erase control bits are blocked |
| strap_err | output | 1 | Sticky: straps changed during sampling |

## Verification
The bench builds the block with `SAMPLE_CYC` = 5 and the default `PROT_BASE` of 0x4000. The short window lets many reset-and-decode rounds run, one for each reset source and strap/lock combination. It also keeps the exact edge where the mode appears easy to observe. A strap flip injected partway through the window exercises the fallback and the sticky error, across a later reset and a power-on clear. `test_en` is raised mid-cycle, both in a settled mode and inside a sampling window, to show the immediate override and the reset needed to leave scan.

// File: rtl/opm_pkg.sv
package opm_pkg;

  typedef enum logic [2:0] {
    OPM_NONE   = 3'd0,
    OPM_NORMAL = 3'd1,
    OPM_PROG   = 3'd2,
    OPM_DEBUG  = 3'd3,
    OPM_TEST   = 3'd4
  } opm_mode_e;

  localparam int MODE_W   = 5;
  localparam int B_NORMAL = 0;
  localparam int B_PROG   = 1;
  localparam int B_DEBUG  = 2;
  localparam int B_TEST   = 3;
  localparam int B_SCAN   = 4;

  // Strap word decode: {hi, lo}; a set lock bit turns the privileged modes into normal.
  function automatic opm_mode_e decode_straps(input logic msel, input logic [1:0] straps,
                                              input logic lock);
    opm_mode_e m;
    if (!msel) begin
      m = OPM_NORMAL;
    end else begin
      case (straps)
        2'b00:   m = OPM_TEST;
        2'b01:   m = lock ? OPM_NORMAL : OPM_PROG;
        2'b10:   m = lock ? OPM_NORMAL : OPM_DEBUG;
        default: m = OPM_NORMAL;
      endcase
    end
    return m;
  endfunction

  function automatic logic [MODE_W-1:0] mode_to_onehot(input opm_mode_e m);
    logic [MODE_W-1:0] v;
    v = '0;
    case (m)
      OPM_NORMAL: v[B_NORMAL] = 1'b1;
      OPM_PROG:   v[B_PROG]   = 1'b1;
      OPM_DEBUG:  v[B_DEBUG]  = 1'b1;
      OPM_TEST:   v[B_TEST]   = 1'b1;
      default:    v = '0;
    endcase
    return v;
  endfunction

  // Write restriction per mode: 1 = flash writes limited.
  function automatic logic mode_restricts(input opm_mode_e m);
    return !(m == OPM_PROG || m == OPM_TEST);
  endfunction

endpackage

// File: rtl/opm_reset_ctl.sv
module opm_reset_ctl (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic brownout,
  input  logic sw_rst_req,
  output logic sys_rst
);
  logic       rst_req_a;
  logic [1:0] stage;

  assign rst_req_a = !por_n || !ext_rst_n || brownout;

  // Asynchronous assertion, two-edge synchronous release; software request restarts the chain.
  always_ff @(posedge clk or posedge rst_req_a) begin
    if (rst_req_a)       stage <= 2'b00;
    else if (sw_rst_req) stage <= 2'b00;
    else                 stage <= {stage[0], 1'b1};
  end

  assign sys_rst = !stage[1];

  // R1
  sw_reset_chk: assert property (@(posedge clk) disable iff (!por_n) sw_rst_req |=> sys_rst);

  // R1
  async_reset_chk: assert property (@(posedge clk) disable iff (!por_n) (!ext_rst_n || brownout) |-> sys_rst);

endmodule

// File: rtl/opm_sync.sv
module opm_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/opm_scan_hold.sv
module opm_scan_hold (
  input  logic clk,
  input  logic por_n,
  input  logic test_en,
  input  logic sys_rst,
  output logic scan_q
);
  // test_en sets asynchronously; clearing needs test_en low and a system reset.
  always_ff @(posedge clk or posedge test_en or negedge por_n) begin
    if (test_en)      scan_q <= 1'b1;
    else if (!por_n)  scan_q <= 1'b0;
    else if (sys_rst) scan_q <= 1'b0;
  end

  // R3
  scan_kept_chk: assert property (@(posedge clk) disable iff (!por_n)
    (scan_q && !sys_rst) |=> scan_q);

  // R2
  scan_set_chk: assert property (@(posedge clk) disable iff (!por_n) test_en |-> scan_q);

endmodule

// File: rtl/opm_sampler.sv
module opm_sampler
  import opm_pkg::*;
#(
  parameter int SAMPLE_CYC = 16
) (
  input  logic      clk,
  input  logic      por_n,
  input  logic      hold,
  input  logic [2:0] sample,   // {msel, strap_hi, strap_lo}, synchronised
  input  logic      lock_bit,
  output opm_mode_e mode,
  output logic      lock_q,
  output logic      done,
  output logic      strap_err
);
  localparam int CNT_W = $clog2(SAMPLE_CYC + 1);
  localparam int LAST  = SAMPLE_CYC - 1;

  logic [CNT_W-1:0] cnt;
  logic [2:0]       first_q;
  logic             mism_q;
  logic             sample_bad;
  logic             decide_now;
  logic             fault;

  assign sample_bad = (cnt != '0) && (sample != first_q);
  assign decide_now = !hold && !done && (cnt == CNT_W'(LAST));
  assign fault      = mism_q || sample_bad;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt       <= '0;
      first_q   <= '0;
      mism_q    <= 1'b0;
      done      <= 1'b0;
      lock_q    <= 1'b0;
      mode      <= OPM_NONE;
      strap_err <= 1'b0;
    end else if (hold) begin
      cnt    <= '0;
      mism_q <= 1'b0;
      done   <= 1'b0;
      mode   <= OPM_NONE;
    end else if (!done) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == '0) first_q <= sample;
      if (sample_bad) mism_q <= 1'b1;
      if (decide_now) begin
        done   <= 1'b1;
        lock_q <= lock_bit;
        mode   <= fault ? OPM_NORMAL : decode_straps(first_q[2], first_q[1:0], lock_bit);
        if (fault) strap_err <= 1'b1;
      end
    end
  end

  // R11
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!por_n || hold)
    done |=> (done && $stable(mode) && $stable(lock_q)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n) strap_err |=> strap_err);

  // R10
  fault_normal_chk: assert property (@(posedge clk) disable iff (!por_n)
    (decide_now && fault) |=> (mode == OPM_NORMAL && strap_err));

endmodule

// File: rtl/opm_mode_select.sv
module opm_mode_select
  import opm_pkg::*;
#(
  parameter int              SAMPLE_CYC = 16,
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] PROT_BASE = 16'h4000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              sw_rst_req,
  input  logic              brownout,
  input  logic              test_en,
  input  logic              msel_en,
  input  logic              strap_hi,
  input  logic              strap_lo,
  input  logic              lock_bit,
  output logic [4:0]        mode_oh,
  output logic              reduced_cmd,
  output logic              wp_en,
  output logic [ADDR_W-1:0] wp_base,
  output logic              ctl_wr_block,
  output logic              strap_err
);
  logic      sys_rst;
  logic      scan_q;
  logic      hold;
  logic [2:0] pins_s;
  opm_mode_e samp_mode;
  logic      samp_lock;
  logic      samp_done;
  opm_mode_e cur_mode;

  opm_reset_ctl u_rst (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .brownout(brownout),
    .sw_rst_req(sw_rst_req), .sys_rst(sys_rst)
  );

  opm_sync #(.W(3)) u_pin_sync (
    .clk(clk), .rst_n(por_n), .d({msel_en, strap_hi, strap_lo}), .q(pins_s)
  );

  opm_scan_hold u_scan (
    .clk(clk), .por_n(por_n), .test_en(test_en), .sys_rst(sys_rst), .scan_q(scan_q)
  );

  assign hold = sys_rst || scan_q;

  opm_sampler #(.SAMPLE_CYC(SAMPLE_CYC)) u_samp (
    .clk(clk), .por_n(por_n), .hold(hold), .sample(pins_s), .lock_bit(lock_bit),
    .mode(samp_mode), .lock_q(samp_lock), .done(samp_done), .strap_err(strap_err)
  );

  assign cur_mode = (sys_rst || !samp_done) ? OPM_NONE : samp_mode;

  always_comb begin
    if (scan_q) begin
      mode_oh         = '0;
      mode_oh[B_SCAN] = 1'b1;
      wp_en           = 1'b1;
      wp_base         = '0;
      reduced_cmd     = 1'b0;
    end else begin
      mode_oh     = mode_to_onehot(cur_mode);
      wp_en       = mode_restricts(cur_mode);
      wp_base     = (cur_mode == OPM_NORMAL) ? PROT_BASE : '0;
      reduced_cmd = (cur_mode == OPM_TEST) && samp_lock;
    end
  end

  assign ctl_wr_block = wp_en;

  // R5
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!por_n) $onehot0(mode_oh));

  // R2
  scan_override_chk: assert property (@(posedge clk) disable iff (!por_n)
    test_en |-> (mode_oh == 5'b10000));

  // R6
  reduced_only_test_chk: assert property (@(posedge clk) disable iff (!por_n)
    reduced_cmd |-> mode_oh[B_TEST]);

  // R7
  open_modes_chk: assert property (@(posedge clk) disable iff (!por_n)
    (mode_oh[B_PROG] || mode_oh[B_TEST]) |-> (!wp_en && !ctl_wr_block));

  // R1
  reset_blank_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && !scan_q) |-> (mode_oh == '0 && ctl_wr_block));

endmodule

// File: tb/opm_mode_select_tb.sv
`timescale 1ns/1ps
module opm_mode_select_tb;
  localparam int          NS = 5;
  localparam logic [15:0] PB = 16'h4000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n = 1'b0, ext_rst_n = 1'b1, sw_rst_req = 1'b0, brownout = 1'b0;
  logic test_en = 1'b0, msel_en = 1'b0, strap_hi = 1'b0, strap_lo = 1'b0, lock_bit = 1'b0;
  logic [4:0]  mode_oh;
  logic        reduced_cmd, wp_en, ctl_wr_block, strap_err;
  logic [15:0] wp_base;

  opm_mode_select #(.SAMPLE_CYC(NS), .ADDR_W(16), .PROT_BASE(PB)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sw_rst_req(sw_rst_req),
    .brownout(brownout), .test_en(test_en), .msel_en(msel_en), .strap_hi(strap_hi),
    .strap_lo(strap_lo), .lock_bit(lock_bit), .mode_oh(mode_oh), .reduced_cmd(reduced_cmd),
    .wp_en(wp_en), .wp_base(wp_base), .ctl_wr_block(ctl_wr_block), .strap_err(strap_err)
  );

  // Reference model state (modes: 0 none, 1 normal, 2 prog, 3 debug, 4 test)
  int     age = 0, scnt = 0, emode = 0;
  bit     scan_reg = 0, decided = 0, mism = 0, err = 0, elock = 0;
  bit [2:0] first = 0;
  bit [2:0] hist[$] = '{3'b000, 3'b000};
  int     vectors = 0, misses = 0;
  bit     chk_on = 0;
  string  cur_req = "R1 reset";

  function automatic int ref_decode(bit m, bit hi, bit lo, bit lk);
    if (!m) return 1;
    if (hi == lo) return lo ? 1 : 4;
    if (lk) return 1;
    return hi ? 3 : 2;
  endfunction

  always @(posedge clk) begin
    bit async_r, srst_b, scan_b;
    bit [2:0] w;
    async_r = !por_n || !ext_rst_n || brownout;
    srst_b  = async_r || (age < 2);
    scan_b  = scan_reg || test_en;
    w = hist[1];
    if (!por_n) begin
      scnt = 0; decided = 0; mism = 0; err = 0; emode = 0;
    end else if (srst_b || scan_b) begin
      scnt = 0; decided = 0; mism = 0; emode = 0;
    end else if (!decided) begin
      if (scnt == 0) first = w;
      else if (w != first) mism = 1;
      if (scnt == NS - 1) begin
        decided = 1;
        elock = lock_bit;
        emode = mism ? 1 : ref_decode(first[2], first[1], first[0], lock_bit);
        if (mism) err = 1;
      end
      scnt++;
    end
    if (test_en) scan_reg = 1;
    else if (!por_n || srst_b) scan_reg = 0;
    if (async_r || sw_rst_req) age = 0;
    else if (age < 1000) age++;
    if (!por_n) hist = '{3'b000, 3'b000};
    else begin
      hist.push_front({msel_en, strap_hi, strap_lo});
      void'(hist.pop_back());
    end
  end

  task automatic check_now();
    logic [4:0] x_oh; logic x_en, x_red; logic [15:0] x_base;
    bit async_n;
    async_n = !por_n || !ext_rst_n || brownout;
    x_oh = 0; x_en = 1; x_base = 0; x_red = 0;
    if (test_en || scan_reg) x_oh = 5'b10000;
    else if (!(async_n || age < 2) && decided) begin
      case (emode)
        1: begin x_oh = 5'b00001; x_base = PB; end
        2: begin x_oh = 5'b00010; x_en = 0; end
        3: x_oh = 5'b00100;
        4: begin x_oh = 5'b01000; x_en = 0; x_red = elock; end
        default: ;
      endcase
    end
    vectors++;
    if (mode_oh !== x_oh || wp_en !== x_en || wp_base !== x_base || reduced_cmd !== x_red ||
        ctl_wr_block !== x_en || strap_err !== err) begin
      misses++;
      $display("FAIL %s t=%0t: act oh=%b en=%b base=%h red=%b gate=%b err=%b exp oh=%b en=%b base=%h red=%b gate=%b err=%b",
               cur_req, $time, mode_oh, wp_en, wp_base, reduced_cmd, ctl_wr_block, strap_err,
               x_oh, x_en, x_base, x_red, x_en, err);
    end
  endtask

  always @(negedge clk) if (chk_on) check_now();

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  // kind: 0 ext pin, 1 software, 2 brown-out, 3 power-on
  task automatic do_reset(input int kind);
    case (kind)
      0: begin ext_rst_n = 0; tick(2); ext_rst_n = 1; end
      1: begin sw_rst_req = 1; tick(1); sw_rst_req = 0; end
      2: begin brownout = 1; tick(2); brownout = 0; end
      default: begin por_n = 0; tick(2); por_n = 1; end
    endcase
  endtask

  task automatic round(input int kind, input bit m, input bit hi, input bit lo, input bit lk);
    msel_en = m; strap_hi = hi; strap_lo = lo; lock_bit = lk;
    do_reset(kind);
    tick(NS + 5);
  endtask

  initial begin
    tick(3);
    chk_on = 1;
    cur_req = "R1/R4/R9 power-on, msel low";
    msel_en = 0; strap_hi = 0; strap_lo = 1;
    por_n = 1;
    tick(NS + 5);
    cur_req = "R5/R7/R8 test mode";      round(0, 1, 0, 0, 0);
    cur_req = "R6 locked test";          round(1, 1, 0, 0, 1);
    cur_req = "R5/R8 programming";       round(2, 1, 0, 1, 0);
    cur_req = "R5/R7 locked prog";       round(0, 1, 0, 1, 1);
    cur_req = "R5/R7 debug";             round(1, 1, 1, 0, 0);
    cur_req = "R5 locked debug";         round(2, 1, 1, 0, 1);
    cur_req = "R5 straps 11";            round(0, 1, 1, 1, 0);
    cur_req = "R4 msel low";             round(1, 0, 0, 0, 0);
    cur_req = "R11 hold after decide";   round(0, 1, 0, 1, 0);
    msel_en = 0; strap_hi = 1; lock_bit = 1; tick(6);
    cur_req = "R10 strap glitch";
    msel_en = 1; strap_hi = 0; strap_lo = 1; lock_bit = 0;
    ext_rst_n = 0; tick(2); ext_rst_n = 1; tick(4);
    strap_lo = 0; tick(NS + 3);
    cur_req = "R10 sticky error";        round(0, 1, 0, 1, 0);
    cur_req = "R2 immediate scan";
    test_en = 1; #0.5; check_now(); tick(3);
    cur_req = "R3 scan kept";
    test_en = 0; tick(6);
    cur_req = "R3 leave via reset";      round(1, 1, 1, 0, 0);
    cur_req = "R2 scan in window";
    ext_rst_n = 0; tick(2); ext_rst_n = 1; tick(3);
    test_en = 1; tick(2); test_en = 0; tick(NS + 4);
    cur_req = "R3 exit after window scan"; round(0, 1, 0, 0, 1);
    cur_req = "R10 power-on clears error"; round(3, 1, 1, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog: act running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule